// File: doc/BRIEF.md
# Unsigned Complex Multiplier

The block multiplies two complex numbers whose four components are unsigned N-bit integers. The first operand is A + jB and the second is C + jD. It returns the real part AC − BD and the imaginary part BC + AD.

Each of the four real products comes from its own column-wise multiplier. That multiplier works in vertical-crosswise fashion: each output column is the sum of the bit-pair products that fall on that column plus the carry from the column below it. One subtractor then forms the real part and one adder forms the imaginary part.

The real part can go negative even though every input is unsigned, so it is returned as a signed two's-complement value one bit wider than a plain product. The imaginary part can exceed 2N bits, so it also carries one extra bit.

An output register stage is present by default and drives a valid strobe. Setting `REG_OUT` to 0 removes the register, and the outputs then follow the inputs combinationally. N is a parameter and may be set to 4, 8 or 16.

Top module: `cmul_top`

## Requirements
- R1: With the register stage on, `re_o` equals A·C − B·D as a signed two's-complement value of 2N+1 bits, for the operands captured with `valid_i`. The operand mapping is A = `a_re_i`, B = `a_im_i`, C = `b_re_i` and D = `b_im_i`.
- R2: `im_o` equals B·C + A·D as an unsigned value of 2N+1 bits.
- R3: A real part below zero is represented exactly. For N = 4, A = 0, B = 15, C = 0 and D = 15 give −225.
- R4: The largest imaginary part needs the extra top bit. For N = 4, all components at 15 give 450.
- R5: For N = 4, (13 + 9j) × (10 + 7j) gives a real part of 67 and an imaginary part of 181.
- R6: `valid_o` is high in the cycle after each rising clock edge that samples `valid_i` high, and low after each edge that samples it low.
- R7: A result appears exactly one clock edge after its operands are sampled, so back-to-back valid inputs yield back-to-back results in the same order.
- R8: While `valid_i` is sampled low, `re_o` and `im_o` keep their previous values whatever the operand inputs do.
- R9: Driving `rst_ni` low clears `valid_o`, `re_o` and `im_o` to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands on the inputs are valid |
| a_re_i | input | N | A, real part of the first operand |
| a_im_i | input | N | B, imaginary part of the first operand |
| b_re_i | input | N | C, real part of the second operand |
| b_im_i | input | N | D, imaginary part of the second operand |
| valid_o | output | 1 | Result valid strobe |
| re_o | output | 2N+1 | Real part, signed two's complement |
| im_o | output | 2N+1 | Imaginary part, unsigned |

## Verification
A column carry dropped or misrouted inside any of the four multipliers corrupts the affected product. That error shows on `re_o` or `im_o` one clock after the faulty operands are sampled. Exhaustive coverage at N = 4 reaches every column sum and every carry chain length. A sign-extension fault in the subtractor shows only when BD exceeds AC, and a truncated adder shows only when the imaginary sum passes 2^(2N); the directed extreme vectors expose both within one cycle. A faulty load enable or valid register shows on the first idle cycle, as a result that changes or as a mismatched strobe.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  // accumulator width for one column: bit products plus incoming carry
  function automatic int col_acc_w(input int n);
    return $clog2(n) + 2;
  endfunction
endpackage

// File: rtl/vc_mult.sv
module vc_mult #(
  parameter int N = 4
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o
);
  import cmul_pkg::*;
  localparam int AW   = col_acc_w(N);
  localparam int NCOL = 2*N - 1;

  logic [AW-1:0] acc;
  logic [AW-1:0] carry;

  // column k sums a[i]&b[k-i] plus carry from column k-1
  always_comb begin
    p_o   = '0;
    carry = '0;
    acc   = '0;
    for (int k = 0; k < NCOL; k++) begin
      acc = carry;
      for (int i = 0; i < N; i++) begin
        if ((k - i) >= 0 && (k - i) < N)
          acc = acc + {{(AW-1){1'b0}}, a_i[i] & b_i[k-i]};
      end
      p_o[k] = acc[0];
      carry  = acc >> 1;
    end
    p_o[2*N-1] = carry[0];
  end
endmodule

// File: rtl/cmul_combine.sv
module cmul_combine #(
  parameter int N = 4
) (
  input  logic [2*N-1:0]        p_ac_i,
  input  logic [2*N-1:0]        p_bd_i,
  input  logic [2*N-1:0]        p_bc_i,
  input  logic [2*N-1:0]        p_ad_i,
  output logic signed [2*N:0]   re_o,
  output logic [2*N:0]          im_o
);
  assign re_o = $signed({1'b0, p_ac_i}) - $signed({1'b0, p_bd_i});
  assign im_o = {1'b0, p_bc_i} + {1'b0, p_ad_i};
endmodule

// File: rtl/cmul_out_stage.sv
module cmul_out_stage #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic signed [2*N:0]   re_i,
  input  logic [2*N:0]          im_i,
  output logic                  valid_o,
  output logic signed [2*N:0]   re_o,
  output logic [2*N:0]          im_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        re_o    <= '0;
        im_o    <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          re_o <= re_i;
          im_o <= im_i;
        end
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign re_o    = re_i;
    assign im_o    = im_i;
  end
endmodule

// File: rtl/cmul_top.sv
module cmul_top #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [N-1:0]          a_re_i,
  input  logic [N-1:0]          a_im_i,
  input  logic [N-1:0]          b_re_i,
  input  logic [N-1:0]          b_im_i,
  output logic                  valid_o,
  output logic signed [2*N:0]   re_o,
  output logic [2*N:0]          im_o
);
  localparam int PW = 2*N;
  localparam int NP = 4;

  // product order: AC, BD, BC, AD
  logic [N-1:0]  op_x [NP];
  logic [N-1:0]  op_y [NP];
  logic [PW-1:0] prod [NP];

  assign op_x[0] = a_re_i;  assign op_y[0] = b_re_i;
  assign op_x[1] = a_im_i;  assign op_y[1] = b_im_i;
  assign op_x[2] = a_im_i;  assign op_y[2] = b_re_i;
  assign op_x[3] = a_re_i;  assign op_y[3] = b_im_i;

  for (genvar g = 0; g < NP; g++) begin : g_mul
    vc_mult #(.N(N)) u_mul (
      .a_i (op_x[g]),
      .b_i (op_y[g]),
      .p_o (prod[g])
    );
  end

  logic signed [2*N:0] re_c;
  logic [2*N:0]        im_c;

  cmul_combine #(.N(N)) u_comb (
    .p_ac_i (prod[0]),
    .p_bd_i (prod[1]),
    .p_bc_i (prod[2]),
    .p_ad_i (prod[3]),
    .re_o   (re_c),
    .im_o   (im_c)
  );

  cmul_out_stage #(.N(N), .REG_OUT(REG_OUT)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .re_i    (re_c),
    .im_i    (im_c),
    .valid_o (valid_o),
    .re_o    (re_o),
    .im_o    (im_o)
  );
endmodule

// File: rtl/cmul_checker.sv
module cmul_checker #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [N-1:0]          a_re_i,
  input logic [N-1:0]          a_im_i,
  input logic [N-1:0]          b_re_i,
  input logic [N-1:0]          b_im_i,
  input logic                  valid_o,
  input logic signed [2*N:0]   re_o,
  input logic [2*N:0]          im_o
);
  logic [2*N-1:0] ac, bd, bc, ad;
  logic signed [2*N+1:0] ref_re;
  logic [2*N+1:0]        ref_im;

  assign ac = a_re_i * b_re_i;
  assign bd = a_im_i * b_im_i;
  assign bc = a_im_i * b_re_i;
  assign ad = a_re_i * b_im_i;
  assign ref_re = $signed({2'b00, ac}) - $signed({2'b00, bd});
  assign ref_im = {2'b00, bc} + {2'b00, ad};

  if (REG_OUT) begin : g_chk
    p_real_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> re_o == $past(ref_re[2*N:0]));
    p_imag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> im_o == $past(ref_im[2*N:0]));
    p_vld_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    p_vld_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(re_o) && $stable(im_o)));
    p_reset_r9: assert property (@(posedge clk_i)
      !rst_ni |-> (!valid_o && re_o == '0 && im_o == '0));
  end
endmodule

bind cmul_top cmul_checker #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .a_re_i  (a_re_i),
  .a_im_i  (a_im_i),
  .b_re_i  (b_re_i),
  .b_im_i  (b_im_i),
  .valid_o (valid_o),
  .re_o    (re_o),
  .im_o    (im_o)
);

// File: tb/tb_cmul_top.sv
module tb_cmul_top;
  localparam int N = 4;
  localparam int M = 1 << N;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [N-1:0] a_re_i = '0, a_im_i = '0, b_re_i = '0, b_im_i = '0;
  logic valid_o;
  logic signed [2*N:0] re_o;
  logic [2*N:0] im_o;

  always #5 clk_i = ~clk_i;

  cmul_top #(.N(N), .REG_OUT(1'b1)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_re_i(a_re_i), .a_im_i(a_im_i), .b_re_i(b_re_i), .b_im_i(b_im_i),
    .valid_o(valid_o), .re_o(re_o), .im_o(im_o)
  );

  typedef struct {
    int    re;
    int    im;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic prev_vi = 1'b0;
  logic signed [2*N:0] last_re = '0;
  logic [2*N:0] last_im = '0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: operands change 1 ns after a rising edge
  task automatic drive(input int a, input int b, input int c, input int d, input string tag);
    exp_t e;
    @(posedge clk_i); #1;
    valid_i = 1'b1;
    a_re_i = N'(a); a_im_i = N'(b); b_re_i = N'(c); b_im_i = N'(d);
    e.re = a*c - b*d;
    e.im = b*c + a*d;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk_i); #1;
    valid_i = 1'b0;
    a_re_i = N'($urandom); a_im_i = N'($urandom);
    b_re_i = N'($urandom); b_im_i = N'($urandom);
  endtask

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    prev_vi <= rst_ni ? valid_i : 1'b0;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_sim();
    end
  end

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(valid_o == prev_vi, "R6 valid strobe", int'(valid_o), int'(prev_vi));
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(re_o) == e.re, {e.tag, " real"}, int'(re_o), e.re);
          check(int'(im_o) == e.im, {e.tag, " imag"}, int'(im_o), e.im);
        end
        last_re = re_o;
        last_im = im_o;
      end else begin
        check(re_o == last_re, "R8 real hold", int'(re_o), int'(last_re));
        check(im_o == last_im, "R8 imag hold", int'(im_o), int'(last_im));
      end
    end
  end

  initial begin
    #2;
    check(valid_o == 1'b0, "R9 reset valid", int'(valid_o), 0);
    check(re_o == '0, "R9 reset real", int'(re_o), 0);
    check(im_o == '0, "R9 reset imag", int'(im_o), 0);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    drive(13, 9, 10, 7, "R5");
    drive(0, 15, 0, 15, "R3");
    drive(15, 15, 15, 15, "R4");
    drive(15, 0, 0, 15, "R4 alt");
    idle(); idle();

    for (int v = 0; v < M*M*M*M; v++) begin
      drive(v & (M-1), (v >> N) & (M-1), (v >> 2*N) & (M-1), (v >> 3*N) & (M-1), "R1 R2 R7");
      if ((v % 5) == 4) idle();
    end
    idle(); idle(); idle();
    check(exp_q.size() == 0, "R7 drained", exp_q.size(), 0);

    // asynchronous reset mid-cycle with a result held
    drive(7, 3, 5, 9, "R1 R2");
    idle();
    @(posedge clk_i); #3;
    rst_ni = 1'b0;
    #1;
    check(valid_o == 1'b0, "R9 async valid", int'(valid_o), 0);
    check(re_o == '0, "R9 async real", int'(re_o), 0);
    check(im_o == '0, "R9 async imag", int'(im_o), 0);
    finish_sim();
  end
endmodule